// File: doc/BRIEF.md
# Vector Word Rotate Execution Unit

This block executes one vector rotate-left-word instruction per clock. Each cycle it takes a 32-bit instruction word and checks it against two encodings. The compact encoding reaches 32 vector registers. The wide encoding reaches 128 vector registers and spreads its register fields over scattered bits. When either encoding matches, the unit reads two 128-bit operands from its own 128-entry vector register file. It rotates every 32-bit lane of operand A to the left by the count held in the same lane of operand B. The result goes back into the destination register.

The unit reports each executed instruction on a one-cycle result strobe, together with the destination index and the value written. A matching one-cycle step pulse stands for the program counter moving on by four bytes. An instruction word that matches neither encoding is dropped without any effect.

After reset the register file holds a fixed pattern, so a caller can predict every operand without loading data first.

Top module: `vrot_exec_unit`

## Requirements
- R1: A word is a compact-form rotate when instr_i[31:26] equals 4 and instr_i[10:0] equals 132 (word 0x10000084 with the register fields cleared). Any other value in those bits is not a compact-form rotate.
- R2: In compact form the destination index is instr_i[25:21], source A is instr_i[20:16] and source B is instr_i[15:11]. These address registers 0 to 31, and the upper two index bits are zero.
- R3: A word is a wide-form rotate when (instr_i AND 0xFC0003D0) equals 0x18000050. The bits outside that mask carry register fields only and do not affect matching.
- R4: In wide form the 7-bit indices are built as follows: destination = {instr_i[3:2], instr_i[25:21]}, source A = {instr_i[10], instr_i[5], instr_i[20:16]}, source B = {instr_i[1:0], instr_i[15:11]}.
- R5: Lane l occupies bits [127-32l : 96-32l], so lane 0 is the most significant word. Result lane l is lane l of A rotated left by lane l of B.
- R6: Only the low 5 bits of each count lane are used. A count of 0 returns the A lane unchanged, a count of 31 is a one-place right rotate, and rotation never adds or drops set bits.
- R7: The register file is written at the clock edge that consumes the instruction. An instruction presented in the very next cycle reads the new value.
- R8: When the destination equals one or both sources, the rotate uses the source values from before the write.
- R9: A word that matches neither encoding gives no result strobe and no step pulse, and leaves every register unchanged.
- R10: One edge after a matching word, valid_o and step_o are 1 for exactly that cycle, wb_idx_o holds the destination index and wb_data_o holds the rotated value.
- R11: While reset is asserted valid_o, step_o, wb_idx_o and wb_data_o are zero. After reset, lane l of register k equals {k[7:0], l[7:0], ~k[7:0], (4k+l)[7:0] XOR 0xA5}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word consumed at each rising edge |
| valid_o | output | 1 | Result strobe for a recognised rotate |
| step_o | output | 1 | One-cycle program-counter advance pulse |
| wb_idx_o | output | 7 | Destination register index written |
| wb_data_o | output | 128 | Value written to the destination register |

## Verification
Every result is due one rising edge after its instruction word is presented. That same edge writes the register file, so a dependent word presented straight afterwards must see the new value.

The bench drives each word on a falling edge and samples the outputs on the next falling edge. It presents the following word at that same moment. As a result, back-to-back words run without idle gaps, and every sample lands half a period away from the edge that produced it.

A dropped word is confirmed at the ports in two ways. Its sampled cycle must show both the strobe and the step pulse low. A later rotate that reads the register the word named must return the value the bench's own model predicts.

// File: rtl/vrot_pkg.sv
package vrot_pkg;
  localparam int unsigned INSTR_W  = 32;
  localparam int unsigned LANE_W   = 32;
  localparam int unsigned LANES    = 4;
  localparam int unsigned VEC_W    = LANE_W * LANES;
  localparam int unsigned IDX_W    = 7;
  localparam int unsigned SIDX_W   = 5;
  localparam int unsigned NREGS    = 1 << IDX_W;
  localparam int unsigned CNT_W    = $clog2(LANE_W);

  localparam logic [5:0]         SHORT_OPC = 6'd4;
  localparam logic [10:0]        SHORT_XO  = 11'd132;
  localparam logic [INSTR_W-1:0] WIDE_MASK = 32'hFC00_03D0;
  localparam logic [INSTR_W-1:0] WIDE_BASE = 32'h1800_0050;

  typedef logic [IDX_W-1:0] ridx_t;
  typedef logic [VEC_W-1:0] vec_t;

  typedef struct packed {
    logic  hit;
    ridx_t vd;
    ridx_t va;
    ridx_t vb;
  } vrot_dec_t;

  // Reset contents of register k
  function automatic vec_t rf_init(int unsigned k);
    vec_t v;
    logic [7:0] kb, lb, cb;
    v  = '0;
    kb = k[7:0];
    for (int unsigned l = 0; l < LANES; l++) begin
      lb = l[7:0];
      cb = 8'((k << 2) + l) ^ 8'hA5;
      v[VEC_W-1-l*LANE_W -: LANE_W] = LANE_W'({kb, lb, ~kb, cb});
    end
    return v;
  endfunction
endpackage

// File: rtl/vrot_decode.sv
module vrot_decode
  import vrot_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output vrot_dec_t          dec_o
);
  logic short_hit, wide_hit;

  always_comb begin
    short_hit = (instr_i[31:26] == SHORT_OPC) && (instr_i[10:0] == SHORT_XO);
    wide_hit  = ((instr_i & WIDE_MASK) == WIDE_BASE);
    dec_o.hit = short_hit | wide_hit;
    if (wide_hit) begin
      dec_o.vd = {instr_i[3:2], instr_i[25:21]};
      dec_o.va = {instr_i[10], instr_i[5], instr_i[20:16]};
      dec_o.vb = {instr_i[1:0], instr_i[15:11]};
    end else begin
      dec_o.vd = {{(IDX_W-SIDX_W){1'b0}}, instr_i[25:21]};
      dec_o.va = {{(IDX_W-SIDX_W){1'b0}}, instr_i[20:16]};
      dec_o.vb = {{(IDX_W-SIDX_W){1'b0}}, instr_i[15:11]};
    end
  end

  always_comb begin
    a_r1_single_format: assert ($onehot0({short_hit, wide_hit}));
    if (short_hit) begin
      a_r2_short_low_bank: assert (dec_o.vd < 7'd32 && dec_o.va < 7'd32 && dec_o.vb < 7'd32);
    end
  end
endmodule

// File: rtl/vrot_regfile.sv
module vrot_regfile
  import vrot_pkg::*;
#(
  parameter int unsigned DEPTH  = NREGS,
  parameter int unsigned DATA_W = VEC_W,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned k = 0; k < DEPTH; k++) mem[k] <= DATA_W'(rf_init(k));
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  // Reads see the pre-write value in the writing cycle
  assign rdata_a_o = mem[raddr_a_i];
  assign rdata_b_o = mem[raddr_b_i];

  a_r7_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem[$past(waddr_i)] == $past(wdata_i));

  a_r9_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> mem[$past(raddr_a_i)] == $past(rdata_a_o));
endmodule

// File: rtl/vrot_lane_rot.sv
module vrot_lane_rot
  import vrot_pkg::*;
#(
  parameter int unsigned W     = LANE_W,
  parameter int unsigned NLANE = LANES,
  localparam int unsigned CW   = $clog2(W),
  localparam int unsigned VW   = W * NLANE
) (
  input  logic [VW-1:0] a_i,
  input  logic [VW-1:0] b_i,
  output logic [VW-1:0] y_o
);
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    localparam int unsigned HI = VW - 1 - l * W;
    logic [W-1:0]   a_w, y_w;
    logic [CW-1:0]  cnt;
    logic [2*W-1:0] dbl;
    logic           unused_cnt_hi;

    assign a_w           = a_i[HI -: W];
    assign cnt           = b_i[HI-W+1 +: CW];
    assign unused_cnt_hi = ^b_i[HI -: (W-CW)];

    always_comb begin
      dbl = {a_w, a_w} << cnt;
      y_w = dbl[2*W-1 -: W];
    end
    assign y_o[HI -: W] = y_w;

    always_comb begin
      a_r6_no_overflow: assert ($countones(y_w) == $countones(a_w));
      if (cnt == '0) begin
        a_r6_zero_count: assert (y_w == a_w);
      end
    end
  end
endmodule

// File: rtl/vrot_exec_unit.sv
module vrot_exec_unit
  import vrot_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               valid_o,
  output logic               step_o,
  output logic [IDX_W-1:0]   wb_idx_o,
  output logic [VEC_W-1:0]   wb_data_o
);
  vrot_dec_t dec;
  vec_t      src_a, src_b, rot;

  vrot_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  vrot_regfile #(
    .DEPTH  (NREGS),
    .DATA_W (VEC_W)
  ) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (dec.hit),
    .waddr_i   (dec.vd),
    .wdata_i   (rot),
    .raddr_a_i (dec.va),
    .raddr_b_i (dec.vb),
    .rdata_a_o (src_a),
    .rdata_b_o (src_b)
  );

  vrot_lane_rot #(
    .W     (LANE_W),
    .NLANE (LANES)
  ) u_rot (
    .a_i (src_a),
    .b_i (src_b),
    .y_o (rot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      step_o    <= 1'b0;
      wb_idx_o  <= '0;
      wb_data_o <= '0;
    end else begin
      valid_o <= dec.hit;
      step_o  <= dec.hit;
      if (dec.hit) begin
        wb_idx_o  <= dec.vd;
        wb_data_o <= rot;
      end
    end
  end

  a_r9_miss_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec.hit |=> !valid_o && !step_o);

  a_r10_idx_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec.hit |=> valid_o && step_o && wb_idx_o == $past(dec.vd));
endmodule

// File: tb/vrot_exec_unit_tb.sv
`timescale 1ns/1ps
module vrot_exec_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [31:0]  instr_i = '0;
  logic         valid_o, step_o;
  logic [6:0]   wb_idx_o;
  logic [127:0] wb_data_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [127:0] mdl [128];
  bit seen_cnt [32];

  always #2.5 clk = ~clk;

  vrot_exec_unit dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .instr_i   (instr_i),
    .valid_o   (valid_o),
    .step_o    (step_o),
    .wb_idx_o  (wb_idx_o),
    .wb_data_o (wb_data_o)
  );

  // R11 reset pattern, written from the requirement
  function automatic logic [127:0] init_reg(int k);
    logic [127:0] v;
    for (int l = 0; l < 4; l++) begin
      logic [7:0] kk, ll, cc;
      kk = k[7:0];
      ll = l[7:0];
      cc = 8'(4 * k + l) ^ 8'hA5;
      v[127-32*l -: 32] = {kk, ll, ~kk, cc};
    end
    return v;
  endfunction

  function automatic logic [31:0] rotw(logic [31:0] a, int s);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[(i + s) % 32] = a[i];
    return r;
  endfunction

  function automatic logic [31:0] short_w(int vd, int va, int vb);
    return {6'd4, 5'(vd), 5'(va), 5'(vb), 11'd132};
  endfunction

  function automatic logic [31:0] wide_w(int vd, int va, int vb);
    logic [31:0] w;
    logic [6:0] d, a, b;
    d = 7'(vd); a = 7'(va); b = 7'(vb);
    w = 32'h1800_0050;
    w[25:21] = d[4:0]; w[3:2] = d[6:5];
    w[20:16] = a[4:0]; w[10] = a[6]; w[5] = a[5];
    w[15:11] = b[4:0]; w[1:0] = b[6:5];
    return w;
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Presents a word now, samples one falling edge later
  task automatic issue_ok(logic [31:0] w, int vd, int va, int vb, string req);
    logic [127:0] exp;
    for (int l = 0; l < 4; l++) begin
      int s;
      s = int'(mdl[vb][96-32*l +: 5]);
      seen_cnt[s] = 1'b1;
      exp[127-32*l -: 32] = rotw(mdl[va][127-32*l -: 32], s);
    end
    instr_i = w;
    @(negedge clk);
    chk(valid_o && step_o, {req, " strobe"}, {126'd0, valid_o, step_o}, 128'd3);
    chk(wb_idx_o == 7'(vd), {req, " idx"}, 128'(wb_idx_o), 128'(vd));
    chk(wb_data_o == exp, {req, " data"}, wb_data_o, exp);
    mdl[vd] = exp;
  endtask

  task automatic issue_bad(logic [31:0] w, string req);
    instr_i = w;
    @(negedge clk);
    chk(!valid_o && !step_o, req, {126'd0, valid_o, step_o}, 128'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 128; k++) mdl[k] = init_reg(k);
    repeat (3) @(negedge clk);
    // R11 outputs during reset
    chk(!valid_o && !step_o && wb_idx_o == 0 && wb_data_o == 0, "R11 reset",
        wb_data_o, 128'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    issue_bad(32'h0, "R10 idle after reset");

    // R6 count 0 in lane 1 (reg 1), count 31 in lane 2 (reg 6), upper count bits set
    issue_ok(short_w(20, 3, 1), 20, 3, 1, "R6 count0");
    issue_ok(short_w(21, 4, 6), 21, 4, 6, "R6 count31");
    issue_bad(32'h0, "R10 pulse ends");

    // R2 R5 compact sweep, back-to-back
    for (int a = 0; a < 32; a++)
      issue_ok(short_w((a*13+5)%32, a, (a*7+3)%32), (a*13+5)%32, a, (a*7+3)%32, "R2 R5 compact");

    // R8 aliasing
    issue_ok(short_w(7, 7, 7), 7, 7, 7, "R8 all alias");
    issue_ok(short_w(10, 10, 2), 10, 10, 2, "R8 dst=A");
    issue_ok(short_w(11, 12, 11), 11, 12, 11, "R8 dst=B");
    issue_ok(wide_w(100, 100, 100), 100, 100, 100, "R8 wide alias");

    // R7 dependent back-to-back
    issue_ok(wide_w(90, 40, 41), 90, 40, 41, "R7 producer");
    issue_ok(wide_w(91, 90, 90), 91, 90, 90, "R7 consumer");

    // R3 R4 wide sweep over every 7-bit index
    for (int n = 0; n < 128; n++)
      issue_ok(wide_w(n, (n*37+11)%128, 127-n), n, (n*37+11)%128, 127-n, "R3 R4 wide");

    // R1 R3 R9 rejected words, all naming register 15
    issue_bad(short_w(15, 1, 2) ^ 32'h0000_0001, "R1 R9 xo 133");
    issue_bad(short_w(15, 1, 2) ^ 32'h0000_0400, "R1 R9 xo high bit");
    issue_bad(short_w(15, 1, 2) ^ 32'h0400_0000, "R1 R9 opcode 5");
    issue_bad(wide_w(15, 1, 2) ^ 32'h0000_0040, "R3 R9 bit25 clear");
    issue_bad(wide_w(15, 1, 2) ^ 32'h0000_0080, "R3 R9 bit24 set");
    issue_bad(wide_w(15, 1, 2) ^ 32'h0000_0010, "R3 R9 bit27 clear");
    issue_bad(wide_w(15, 1, 2) ^ 32'h0000_0200, "R3 R9 bit22 set");
    issue_bad(wide_w(15, 1, 2) ^ 32'h0400_0000, "R3 R9 opcode 7");
    issue_ok(short_w(16, 15, 1), 16, 15, 1, "R9 readback");
    issue_ok(short_w(17, 1, 15), 17, 1, 15, "R9 readback B");
    issue_bad(32'h0, "R10 final idle");

    chk(seen_cnt[0] && seen_cnt[31], "R6 counts 0 and 31 covered",
        {126'd0, seen_cnt[0], seen_cnt[31]}, 128'd3);
    finish_run();
  end
endmodule